// File: doc/BRIEF.md
# USB Full-Speed Serial Transmitter

This block turns a byte stream from a UTMI-style transmit handshake into the raw differential line signals of a full-speed USB link. Every packet opens with a fixed synchronisation byte, carries the sender's bytes least-significant bit first, gets a zero inserted after every run of six ones, and is NRZI-coded onto the D+/D- pair. The packet closes with an end-of-packet sequence, after which the output-enable is released. The line rests at J with the output-enable low whenever no packet is in flight.

The block runs on a single 48 MHz clock. A one-in-four strobe, `bit_tick`, marks each 12 MHz cycle, and each strobe is one bit time on the wire. The byte handshake counts only on strobe cycles: a byte is taken on a strobe where both `tx_valid` and `tx_ready` are high. When the sender lowers `tx_valid` at a byte boundary, the packet ends.

Two control inputs gate the output. An operating-mode code can keep the lines undriven or turn off bit stuffing. A speed-select value of 0b00 keeps the lines undriven no matter what else is set, so that a high-speed detection handshake can use the wires without interference. In both undriven cases the serial engine keeps running with unchanged handshake timing, and only the output-enable is masked.

The controller has six states:
- `ST_IDLE`: the line rests at J with the output-enable low.
- `ST_SYNC`: the sync byte is being sent.
- `ST_DATA`: data bytes are being sent.
- `ST_SE0_A`: the first SE0 bit time of the end-of-packet is on the wire.
- `ST_SE0_B`: the second SE0 bit time is on the wire.
- `ST_EOP_J`: the final J bit time is on the wire.

The transitions are:
- IDLE→SYNC on a strobe with `tx_valid` high.
- SYNC→DATA, and DATA→DATA, when the shifter is empty and a byte is accepted.
- SYNC→SE0_A or DATA→SE0_A when the shifter is empty and `tx_valid` is low.
- SE0_A→SE0_B→EOP_J→IDLE on successive strobes.

A due stuff bit is sent ahead of any byte fetch or end-of-packet.

Top module: `usbfs_tx`

## Requirements
- R1: After reset, `usb_oe_o` is low, `tx_ready` is low and the line rests at J (`usb_dp_o`=1, `usb_dn_o`=0).
- R2: The strobe that sees `tx_valid` high in idle leaves the line undriven. The next eight strobes send the sync byte 8'h80 least-significant bit first, which gives the symbols K J K J K J K K.
- R3: NRZI coding: a 0 bit toggles the line between J and K, and a 1 bit holds it. J is D+ high with D- low, K is D+ low with D- high, and the first coded bit is referenced to J.
- R4: Each data byte is sent least-significant bit first, one bit per strobe, straight after the sync byte or the previous byte.
- R5: After six consecutive 1 bits on the wire, counting the last sync bit and runs that span bytes, one 0 bit is inserted. This includes a run that ends at the final byte, before the end-of-packet.
- R6: `tx_ready` is high only on a strobe cycle, once per accepted byte, on the strobe that puts that byte's first bit on the wire. A stuff bit due at a byte boundary delays `tx_ready` by one strobe.
- R7: End-of-packet is two bit times of SE0 (both lines low, enable high), then one bit time of J, then the output-enable falls.
- R8: With `op_mode`=2 no stuff bits are inserted. Codes 0 and 3 act as normal mode.
- R9: With `op_mode`=1, `usb_oe_o` stays low while `tx_ready` timing is unchanged from normal mode.
- R10: With `xcvr_select`=0b00, `usb_oe_o` stays low for every `op_mode`. Stuffing still follows `op_mode` for the handshake timing.
- R11: The line outputs change only in the cycle right after a strobe while the mode inputs are steady.
- R12: If `tx_valid` falls before the sync byte completes, the sync byte is followed directly by the end-of-packet, and no byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz bit-timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-in-four strobe marking each bit time and 12 MHz cycle |
| tx_data | input | DATA_W (8) | Byte to send; valid while `tx_valid` is high |
| tx_valid | input | 1 | Sender has a byte; falling at a byte boundary ends the packet |
| tx_ready | output | 1 | Current byte accepted on this strobe |
| op_mode | input | 2 | 0/3 normal, 1 undriven, 2 stuffing off |
| xcvr_select | input | 2 | 0b00 keeps the lines undriven |
| usb_dp_o | output | 1 | D+ level |
| usb_dn_o | output | 1 | D- level |
| usb_oe_o | output | 1 | Output-enable for D+/D- |

## Verification
The insertion of a stuff bit can fall on the same strobe as a byte-boundary decision, whether that decision is fetching the next byte or starting the end-of-packet. The stuff bit must win, which delays `tx_ready` or the first SE0. The bench provokes this with bytes whose high-order run of ones ends exactly at bit 7 (for example 8'hFC), followed either by another byte or by nothing, and with a sweep of all 256 single-byte packets. For each packet the bench computes the full symbol stream and the strobe index of each `tx_ready` arithmetically, then compares both.

// File: rtl/usbfs_tx_pkg.sv
package usbfs_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_SE0_A,
        ST_SE0_B,
        ST_EOP_J
    } tx_state_e;

    typedef enum logic [2:0] {
        LN_HOLD,
        LN_BIT,
        LN_SE0,
        LN_J,
        LN_IDLE
    } line_cmd_e;

    localparam logic [1:0] OPM_NODRIVE   = 2'd1;
    localparam logic [1:0] OPM_NOSTUFF   = 2'd2;
    localparam logic [1:0] XSEL_HS_PROBE = 2'b00;

endpackage

// File: rtl/usbfs_tx_shifter.sv
module usbfs_tx_shifter #(
    parameter int               DATA_W   = 8,
    parameter logic [DATA_W-1:0] SYNC_PAT = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_sync,
    input  logic              load_data,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    output logic              bit_o,
    output logic              empty_o
);
    localparam int CW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sh;
    logic [CW-1:0]     rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            rem <= '0;
        end else if (tick) begin
            if (load_sync) begin
                sh  <= SYNC_PAT;
                rem <= CW'(DATA_W);
            end else if (load_data) begin
                // bit 0 leaves on this strobe, the rest wait
                sh  <= data >> 1;
                rem <= CW'(DATA_W - 1);
            end else if (shift) begin
                sh  <= sh >> 1;
                rem <= rem - 1'b1;
            end
        end
    end

    assign bit_o   = load_data ? data[0] : sh[0];
    assign empty_o = (rem == '0);

endmodule

// File: rtl/usbfs_tx_stuffer.sv
module usbfs_tx_stuffer #(
    parameter int RUN_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    input  logic fire,
    input  logic bit_i,
    input  logic en,
    output logic due
);
    localparam int          CW    = $clog2(RUN_LEN + 2);
    localparam logic [CW-1:0] RUN_C = CW'(RUN_LEN);
    localparam logic [CW-1:0] SAT_C = CW'(RUN_LEN + 1);

    logic [CW-1:0] ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones <= '0;
        end else if (tick) begin
            if (clr) begin
                ones <= '0;
            end else if (fire) begin
                if (!bit_i)
                    ones <= '0;
                else if (ones != SAT_C)
                    ones <= ones + 1'b1;
            end
        end
    end

    assign due = en && (ones == RUN_C);

endmodule

// File: rtl/usbfs_tx_line.sv
module usbfs_tx_line
    import usbfs_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  line_cmd_e cmd,
    input  logic      bit_i,
    output logic      dp_o,
    output logic      dn_o,
    output logic      oe_o
);
    logic lvl_j;
    logic se0;
    logic oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_j <= 1'b1;
            se0   <= 1'b0;
            oe    <= 1'b0;
        end else if (tick) begin
            unique case (cmd)
                LN_BIT: begin
                    oe  <= 1'b1;
                    se0 <= 1'b0;
                    if (!bit_i)
                        lvl_j <= ~lvl_j;
                end
                LN_SE0: begin
                    oe  <= 1'b1;
                    se0 <= 1'b1;
                end
                LN_J: begin
                    oe    <= 1'b1;
                    se0   <= 1'b0;
                    lvl_j <= 1'b1;
                end
                LN_IDLE: begin
                    oe    <= 1'b0;
                    se0   <= 1'b0;
                    lvl_j <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign dp_o = !se0 && lvl_j;
    assign dn_o = !se0 && !lvl_j;
    assign oe_o = oe;

endmodule

// File: rtl/usbfs_tx_fsm.sv
module usbfs_tx_fsm
    import usbfs_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      tx_valid,
    input  logic      empty,
    input  logic      stuff_due,
    input  logic      ser_bit,
    output logic      tx_ready,
    output logic      load_sync,
    output logic      load_data,
    output logic      shift,
    output logic      ones_clr,
    output logic      bit_fire,
    output logic      bit_val,
    output line_cmd_e cmd
);
    tx_state_e state;
    tx_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (tick)
            state <= nxt;
    end

    always_comb begin
        nxt       = state;
        tx_ready  = 1'b0;
        load_sync = 1'b0;
        load_data = 1'b0;
        shift     = 1'b0;
        ones_clr  = 1'b0;
        bit_fire  = 1'b0;
        bit_val   = 1'b0;
        cmd       = LN_HOLD;
        unique case (state)
            ST_IDLE: begin
                cmd = LN_IDLE;
                if (tx_valid) begin
                    load_sync = 1'b1;
                    ones_clr  = 1'b1;
                    nxt       = ST_SYNC;
                end
            end
            ST_SYNC, ST_DATA: begin
                if (stuff_due) begin
                    // inserted zero outranks fetch and end-of-packet
                    cmd      = LN_BIT;
                    bit_fire = 1'b1;
                    bit_val  = 1'b0;
                end else if (empty) begin
                    if (tx_valid) begin
                        tx_ready  = tick;
                        load_data = 1'b1;
                        cmd       = LN_BIT;
                        bit_fire  = 1'b1;
                        bit_val   = ser_bit;
                        nxt       = ST_DATA;
                    end else begin
                        cmd = LN_SE0;
                        nxt = ST_SE0_A;
                    end
                end else begin
                    cmd      = LN_BIT;
                    bit_fire = 1'b1;
                    bit_val  = ser_bit;
                    shift    = 1'b1;
                end
            end
            ST_SE0_A: begin
                cmd = LN_SE0;
                nxt = ST_SE0_B;
            end
            ST_SE0_B: begin
                cmd = LN_J;
                nxt = ST_EOP_J;
            end
            ST_EOP_J: begin
                cmd = LN_IDLE;
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/usbfs_tx.sv
module usbfs_tx
    import usbfs_tx_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] SYNC_PAT  = 8'h80,
    parameter int               STUFF_RUN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [1:0]        op_mode,
    input  logic [1:0]        xcvr_select,
    output logic              usb_dp_o,
    output logic              usb_dn_o,
    output logic              usb_oe_o
);
    logic      load_sync, load_data, shift, ones_clr;
    logic      bit_fire, bit_val, ser_bit, empty, stuff_due;
    logic      oe_raw, drive_ok, stuff_en;
    line_cmd_e cmd;

    assign stuff_en = (op_mode != OPM_NOSTUFF);
    assign drive_ok = (op_mode != OPM_NODRIVE) && (xcvr_select != XSEL_HS_PROBE);

    usbfs_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .tx_valid  (tx_valid),
        .empty     (empty),
        .stuff_due (stuff_due),
        .ser_bit   (ser_bit),
        .tx_ready  (tx_ready),
        .load_sync (load_sync),
        .load_data (load_data),
        .shift     (shift),
        .ones_clr  (ones_clr),
        .bit_fire  (bit_fire),
        .bit_val   (bit_val),
        .cmd       (cmd)
    );

    usbfs_tx_shifter #(
        .DATA_W   (DATA_W),
        .SYNC_PAT (SYNC_PAT)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .load_sync (load_sync),
        .load_data (load_data),
        .shift     (shift),
        .data      (tx_data),
        .bit_o     (ser_bit),
        .empty_o   (empty)
    );

    usbfs_tx_stuffer #(
        .RUN_LEN (STUFF_RUN)
    ) u_stuff (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .clr   (ones_clr),
        .fire  (bit_fire),
        .bit_i (bit_val),
        .en    (stuff_en),
        .due   (stuff_due)
    );

    usbfs_tx_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .cmd   (cmd),
        .bit_i (bit_val),
        .dp_o  (usb_dp_o),
        .dn_o  (usb_dn_o),
        .oe_o  (oe_raw)
    );

    // gate after the register: masking is immediate, engine timing untouched
    assign usb_oe_o = oe_raw && drive_ok;

endmodule

// File: rtl/usbfs_tx_chk.sv
module usbfs_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       tx_ready,
    input logic [1:0] op_mode,
    input logic [1:0] xcvr_select,
    input logic       usb_dp_o,
    input logic       usb_dn_o,
    input logic       usb_oe_o
);
    // R10
    hs_probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_select == 2'b00) |-> !usb_oe_o);

    // R9
    nodrive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'd1) |-> !usb_oe_o);

    // R6
    ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> bit_tick);

    // R11
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bit_tick) && $stable(op_mode) && $stable(xcvr_select))
        |-> $stable({usb_dp_o, usb_dn_o, usb_oe_o}));

    // R7
    release_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(usb_oe_o) && $stable(op_mode) && $stable(xcvr_select))
        |-> $past(usb_dp_o && !usb_dn_o));

    // R3
    no_se1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usb_oe_o |-> !(usb_dp_o && usb_dn_o));
endmodule

bind usbfs_tx usbfs_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .tx_ready    (tx_ready),
    .op_mode     (op_mode),
    .xcvr_select (xcvr_select),
    .usb_dp_o    (usb_dp_o),
    .usb_dn_o    (usb_dn_o),
    .usb_oe_o    (usb_oe_o)
);

// File: tb/tb_usbfs_tx.sv
module tb_usbfs_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic [1:0] op_mode = 2'd0;
    logic [1:0] xcvr_select = 2'b01;
    logic       tx_ready, usb_dp_o, usb_dn_o, usb_oe_o;

    usbfs_tx dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .op_mode     (op_mode),
        .xcvr_select (xcvr_select),
        .usb_dp_o    (usb_dp_o),
        .usb_dn_o    (usb_dn_o),
        .usb_oe_o    (usb_oe_o)
    );

    always #2 clk = ~clk;

    int  cyc = 0;
    bit  timed_out = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) timed_out <= 1'b1;
    end

    int n_chk = 0, n_bad = 0;
    // symbol codes: 0 undriven, 1 J, 2 K, 3 SE0
    int exp_sym[0:511]; int exp_rdy[0:63]; int n_sym, n_rdy;
    int got_sym[0:511]; int got_rdy[0:63]; int g_sym, g_rdy;
    logic [7:0] pkt[0:15];
    int  cur_n, idx, ph = 0, tick_idx, prev_sym = 0, stab_bad = 0, offtick_rdy = 0;
    bit  last_tick = 0, last_ready = 0, recording = 0, start_req = 0;
    int  m_line, m_ones;

    function automatic int sym_now();
        if (!usb_oe_o) return 0;
        if (usb_dp_o && !usb_dn_o) return 1;
        if (!usb_dp_o && usb_dn_o) return 2;
        if (!usb_dp_o && !usb_dn_o) return 3;
        return 4;
    endfunction

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put_bit(input int b);
        if (b == 0) m_line = 1 - m_line;
        exp_sym[n_sym] = (m_line == 1) ? 1 : 2;
        n_sym++;
        m_ones = (b != 0) ? m_ones + 1 : 0;
    endtask

    task automatic build(input int n, input bit stuff_en, input bit gated);
        m_line = 1; m_ones = 0; n_sym = 0; n_rdy = 0;
        exp_sym[0] = 0; n_sym = 1;
        for (int i = 0; i < 8; i++) put_bit((8'h80 >> i) & 1);
        for (int m = 0; m < n; m++) begin
            for (int i = 0; i < 8; i++) begin
                if (stuff_en && m_ones == 6) put_bit(0);
                if (i == 0) begin exp_rdy[n_rdy] = n_sym; n_rdy++; end
                put_bit((pkt[m] >> i) & 1);
            end
        end
        if (stuff_en && m_ones == 6) put_bit(0);
        exp_sym[n_sym] = 3; exp_sym[n_sym+1] = 3; exp_sym[n_sym+2] = 1; exp_sym[n_sym+3] = 0;
        n_sym += 4;
        if (gated) for (int i = 0; i < n_sym; i++) exp_sym[i] = 0;
    endtask

    task automatic step();
        @(negedge clk);
        if (recording && last_tick && g_sym < 512) begin got_sym[g_sym] = sym_now(); g_sym++; end
        if (recording && !last_tick && sym_now() != prev_sym) stab_bad++;
        prev_sym = sym_now();
        if (last_ready) begin
            idx++;
            if (idx < cur_n) tx_data = pkt[idx]; else tx_valid = 1'b0;
        end
        if (recording && last_tick && tick_idx == 1 && cur_n == 0) tx_valid = 1'b0;
        if (start_req && ph == 0) begin
            tx_valid = 1'b1;
            tx_data = (cur_n > 0) ? pkt[0] : 8'h00;
            recording = 1'b1; tick_idx = 0; start_req = 1'b0;
        end
        bit_tick = (ph == 0);
        ph = (ph + 1) % 4;
        #1;
        if (tx_ready && !bit_tick) offtick_rdy++;
        last_tick = bit_tick;
        last_ready = bit_tick && tx_ready;
        if (recording && bit_tick) begin
            if (tx_ready && g_rdy < 64) begin got_rdy[g_rdy] = tick_idx; g_rdy++; end
            tick_idx++;
        end
    endtask

    task automatic run_pkt(input int n, input string ts, input string tr);
        bit stuff_en, gated;
        int bad_i, ok_r;
        stuff_en = (op_mode != 2'd2);
        gated = (op_mode == 2'd1) || (xcvr_select == 2'b00);
        build(n, stuff_en, gated);
        cur_n = n; idx = 0; g_sym = 0; g_rdy = 0; start_req = 1'b1;
        while (!(recording && g_sym >= n_sym) && !timed_out) step();
        recording = 1'b0;
        for (int i = 0; i < 6; i++) step();
        bad_i = -1;
        for (int i = 0; i < n_sym; i++)
            if (bad_i < 0 && got_sym[i] != exp_sym[i]) bad_i = i;
        check($sformatf("%s stream sym#%0d", ts, bad_i), bad_i < 0,
              (bad_i < 0) ? 0 : got_sym[bad_i], (bad_i < 0) ? 0 : exp_sym[bad_i]);
        ok_r = (g_rdy == n_rdy);
        for (int i = 0; i < n_rdy && i < g_rdy; i++)
            if (got_rdy[i] != exp_rdy[i]) ok_r = 0;
        check($sformatf("%s ready strobes count/first", tr), ok_r != 0,
              g_rdy * 1000 + ((g_rdy > 0) ? got_rdy[0] : 0),
              n_rdy * 1000 + ((n_rdy > 0) ? exp_rdy[0] : 0));
    endtask

    initial begin
        for (int i = 0; i < 4; i++) step();
        // R1 reset state
        check("R1 oe in reset", usb_oe_o == 1'b0, usb_oe_o, 0);
        check("R1 ready in reset", tx_ready == 1'b0, tx_ready, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step();
        check("R1 idle J", {usb_dp_o, usb_dn_o, usb_oe_o} == 3'b100,
              {usb_dp_o, usb_dn_o, usb_oe_o}, 3'b100);

        // R2 R3 R4 basic two-byte packet
        pkt[0] = 8'hA5; pkt[1] = 8'h3C;
        run_pkt(2, "R3 R4 basic", "R6 basic");
        begin
            int kj[0:8] = '{0, 2, 1, 2, 1, 2, 1, 2, 2};
            int bad = 0;
            for (int i = 0; i < 9; i++) if (got_sym[i] != kj[i]) bad++;
            check("R2 sync symbols", bad == 0, bad, 0);
        end

        // R4 R3 all single-byte values
        for (int v = 0; v < 256; v++) begin
            pkt[0] = 8'(v);
            run_pkt(1, "R4 sweep", "R6 sweep");
        end

        // R5 long runs of ones across bytes
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF;
        run_pkt(3, "R5 ones run", "R6 ones run");
        // R5 stuff due right before end-of-packet; R7 framing
        pkt[0] = 8'hFC;
        run_pkt(1, "R5 R7 stuff before eop", "R6 stuff before eop");
        // R6 stuff coincides with byte boundary
        pkt[0] = 8'hFC; pkt[1] = 8'h01;
        run_pkt(2, "R5 boundary", "R6 ready delayed by stuff");

        // R8 stuffing disabled
        op_mode = 2'd2;
        pkt[0] = 8'hFF; pkt[1] = 8'hFF;
        run_pkt(2, "R8 no stuff", "R8 ready");
        op_mode = 2'd0;

        // R9 R10 mode sweep
        pkt[0] = 8'hFF; pkt[1] = 8'h00; pkt[2] = 8'hFC;
        for (int om = 0; om < 4; om++) begin
            for (int xs = 0; xs < 4; xs++) begin
                op_mode = 2'(om); xcvr_select = 2'(xs);
                for (int i = 0; i < 4; i++) step();
                if (xs == 0) run_pkt(3, "R10 hs probe gate", "R10 ready");
                else if (om == 1) run_pkt(3, "R9 nodrive gate", "R9 ready");
                else run_pkt(3, "R8 mode sweep", "R6 mode sweep");
            end
        end
        op_mode = 2'd0; xcvr_select = 2'b01;
        for (int i = 0; i < 4; i++) step();

        // R12 zero-length packet
        run_pkt(0, "R12 empty packet", "R12 no byte taken");

        // length sweep
        for (int n = 1; n <= 6; n++) begin
            for (int k = 0; k < n; k++) pkt[k] = 8'(k * 91 + n * 17);
            run_pkt(n, "R4 length sweep", "R6 length sweep");
        end

        // R11 outputs quiet off-strobe, ready only on strobes
        check("R11 off-strobe changes", stab_bad == 0, stab_bad, 0);
        check("R6 off-strobe ready", offtick_rdy == 0, offtick_rdy, 0);
        if (timed_out) check("watchdog", 1'b0, cyc, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule